// File: doc/BRIEF.md
# Non-volatile image checksum sequencer

This block walks the word image of a non-volatile memory through a plain request/acknowledge word port and keeps a 16-bit running sum that wraps on overflow. A correct image is one whose words, from index 0 up to and including the checksum slot, add up modulo 2^16 to the signature 0xBABA. In check mode the sequencer reads every word up to and including the checksum slot and reports whether the total matches. In fix mode it reads the words below the checksum slot and then writes the one value that makes the total match into the slot.

One pulse on `start_i` launches an operation, and `mode_i` picks the kind. `busy_o` is high for the whole operation. `done_o` pulses once at the end, and `err_o` then gives the outcome and holds it until the next start. The port below the sequencer may report a failure on any access, and that ends the operation.

The states are S_IDLE, S_READ, S_WRITE and S_DONE.
- S_IDLE goes to S_READ on a start. In fix mode with a checksum slot at index 0 it goes straight to S_WRITE.
- S_READ stays put until the port answers. An ack below the last index moves to the next index. An ack at the last index moves to S_WRITE in fix mode, or to S_DONE in check mode, where the sum is judged. A failure moves to S_DONE.
- S_WRITE goes to S_DONE on an ack or on a failure.
- S_DONE returns to S_IDLE after one cycle.

Top module: `nvm_sum_engine`

## Requirements
- R1: In check mode (mode_i = 0) reads are issued one at a time at addresses 0, 1, …, CK_IDX (default 63) in ascending order. The address advances only after `ack_i`.
- R2: In check mode `err_o` is 0 at the `done_o` pulse exactly when the 16-bit wrapping sum of all words read equals 16'hBABA. Otherwise it is 1.
- R3: In fix mode (mode_i = 1) only addresses 0 … CK_IDX−1 are read. Then exactly one write is issued to address CK_IDX, carrying 16'hBABA minus the 16-bit sum of those words, modulo 2^16.
- R4: A `fail_i` answering a read ends the operation. No further request is issued, `done_o` pulses and `err_o` is 1.
- R5: A `fail_i` answering the write in fix mode gives `err_o` = 1 at the `done_o` pulse.
- R6: A `start_i` seen while `busy_o` is high has no effect on the address sequence, the mode or the number of `done_o` pulses.
- R7: `busy_o` rises in the cycle after an accepted start and stays high through the `done_o` cycle. `done_o` lasts one cycle and `busy_o` is low in the next.
- R8: After reset `busy_o`, `done_o`, `rd_req_o`, `wr_req_o` and `err_o` are all 0.
- R9: `err_o` keeps its value after `done_o` until the next accepted start, which clears it.
- R10: A request stays high with a stable address until `ack_i` or `fail_i` arrives, and `rd_req_o` and `wr_req_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch an operation when idle |
| mode_i | input | 1 | 0 = check image, 1 = fix checksum slot |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Outcome: 1 = mismatch or port failure |
| rd_req_o | output | 1 | Word read request, held until answered |
| wr_req_o | output | 1 | Word write request, held until answered |
| addr_o | output | AW | Word index of the current request |
| wdata_o | output | DW | Write data (checksum correction) |
| rdata_i | input | DW | Read data, valid with ack_i |
| ack_i | input | 1 | Port completed the request |
| fail_i | input | 1 | Port failed the request |

## Verification
The hardest case to reach is a failure in the middle of a long read walk, combined with a start arriving while the walk is under way. Either event could disturb the index or the mode if it leaked into the state. The bench's memory responder injects a failure on a chosen index and a stray start with the opposite mode at a chosen point. A reference walk in the bench then confirms the exact count of reads and writes. A fix operation followed by a check over images with wrapping sums shows that the written correction closes the sum.

// File: rtl/nvm_sum_pkg.sv
package nvm_sum_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2,
        S_DONE  = 2'd3
    } sum_state_e;

    typedef enum logic {
        OP_CHECK = 1'b0,
        OP_FIX   = 1'b1
    } sum_op_e;
endpackage

// File: rtl/nvm_sum_acc.sv
module nvm_sum_acc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          add_i,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] sum_o,
    output logic [DW-1:0] sum_next_o
);
    logic [DW-1:0] sum_q;

    assign sum_next_o = sum_q + word_i;
    assign sum_o      = sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sum_q <= '0;
        else if (clr_i) sum_q <= '0;
        else if (add_i) sum_q <= sum_next_o;
    end
endmodule

// File: rtl/nvm_word_idx.sv
module nvm_word_idx #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [AW-1:0] idx_o
);
    logic [AW-1:0] idx_q;

    assign idx_o = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     idx_q <= '0;
        else if (clr_i) idx_q <= '0;
        else if (inc_i) idx_q <= idx_q + 1'b1;
    end
endmodule

// File: rtl/nvm_sum_engine.sv
module nvm_sum_engine
    import nvm_sum_pkg::*;
#(
    parameter int          AW     = 8,
    parameter int          DW     = 16,
    parameter int          CK_IDX = 63,
    parameter logic [15:0] SIG    = 16'hBABA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic          rd_req_o,
    output logic          wr_req_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    input  logic [DW-1:0] rdata_i,
    input  logic          ack_i,
    input  logic          fail_i
);
    localparam logic [AW-1:0] CK_ADDR  = AW'(CK_IDX);
    localparam logic [AW-1:0] FIX_LAST = AW'(CK_IDX - 1);
    localparam logic [DW-1:0] SIG_W    = DW'(SIG);
    localparam bit            NO_READS = (CK_IDX == 0);

    sum_state_e    state_q, state_d;
    sum_op_e       op_q;
    logic          err_q;
    logic          err_set;
    logic          acc_clr, acc_add;
    logic          idx_clr, idx_inc;
    logic [AW-1:0] idx;
    logic [DW-1:0] sum, sum_next;
    logic [AW-1:0] last_idx;
    logic          at_last;
    logic          accept;

    nvm_sum_acc #(.DW(DW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (acc_clr),
        .add_i      (acc_add),
        .word_i     (rdata_i),
        .sum_o      (sum),
        .sum_next_o (sum_next)
    );

    nvm_word_idx #(.AW(AW)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (idx_clr),
        .inc_i (idx_inc),
        .idx_o (idx)
    );

    assign last_idx = (op_q == OP_FIX) ? FIX_LAST : CK_ADDR;
    assign at_last  = (idx == last_idx);
    assign accept   = (state_q == S_IDLE) && start_i;

    // Next-state and datapath control
    always_comb begin
        state_d = state_q;
        acc_clr = 1'b0;
        acc_add = 1'b0;
        idx_clr = 1'b0;
        idx_inc = 1'b0;
        err_set = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    acc_clr = 1'b1;
                    idx_clr = 1'b1;
                    state_d = (mode_i && NO_READS) ? S_WRITE : S_READ;
                end
            end
            S_READ: begin
                if (fail_i) begin
                    err_set = 1'b1;
                    state_d = S_DONE;
                end else if (ack_i) begin
                    acc_add = 1'b1;
                    if (at_last) begin
                        if (op_q == OP_FIX) begin
                            state_d = S_WRITE;
                        end else begin
                            err_set = (sum_next != SIG_W);
                            state_d = S_DONE;
                        end
                    end else begin
                        idx_inc = 1'b1;
                    end
                end
            end
            S_WRITE: begin
                if (fail_i) begin
                    err_set = 1'b1;
                    state_d = S_DONE;
                end else if (ack_i) begin
                    state_d = S_DONE;
                end
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_CHECK;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q  <= sum_op_e'(mode_i);
                err_q <= 1'b0;
            end else if (err_set) begin
                err_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o   = (state_q != S_IDLE);
        done_o   = (state_q == S_DONE);
        rd_req_o = (state_q == S_READ);
        wr_req_o = (state_q == S_WRITE);
        addr_o   = (state_q == S_WRITE) ? CK_ADDR : idx;
        wdata_o  = SIG_W - sum;
        err_o    = err_q;
    end
endmodule

// File: rtl/nvm_sum_chk.sv
module nvm_sum_chk #(
    parameter int AW     = 8,
    parameter int CK_IDX = 63
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          done_o,
    input logic          rd_req_o,
    input logic          wr_req_o,
    input logic [AW-1:0] addr_o,
    input logic          ack_i,
    input logic          fail_i
);
    // R10
    excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));

    // R10
    held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !ack_i && !fail_i) |=> (rd_req_o && $stable(addr_o)));

    // R1
    step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && ack_i && !fail_i) |=>
            (!rd_req_o || addr_o == AW'($past(addr_o) + 1'b1)));

    // R3
    wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (addr_o == AW'(CK_IDX)));

    // R4
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && fail_i) |=> (done_o && !rd_req_o && !wr_req_o));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

bind nvm_sum_engine nvm_sum_chk #(.AW(AW), .CK_IDX(CK_IDX)) u_sum_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .rd_req_o (rd_req_o),
    .wr_req_o (wr_req_o),
    .addr_o   (addr_o),
    .ack_i    (ack_i),
    .fail_i   (fail_i)
);

// File: tb/tb_nvm_sum_engine.sv
`timescale 1ns/1ps
module tb_nvm_sum_engine;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CK = 63;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic          busy_o, done_o, err_o, rd_req_o, wr_req_o;
    logic [AW-1:0] addr_o;
    logic [DW-1:0] wdata_o;
    logic [DW-1:0] rdata_i = '0;
    logic          ack_i = 1'b0;
    logic          fail_i = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] mem [0:CK];

    always #2 clk = ~clk;

    nvm_sum_engine #(.AW(AW), .DW(DW), .CK_IDX(CK)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .rd_req_o(rd_req_o), .wr_req_o(wr_req_o), .addr_o(addr_o),
        .wdata_o(wdata_o), .rdata_i(rdata_i), .ack_i(ack_i), .fail_i(fail_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] sum_to(input int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    // mode: 0 check, 1 fix; fail_at: read index to fail (-1 none)
    task automatic run_op(input bit mode, input int lat, input int fail_at,
                          input bit wfail, input int poke_at);
        int          exp_idx, reads, writes, wait_cnt, steps, exp_reads, exp_writes;
        bit          exp_err, seen_done;
        logic [15:0] exp_wdata;
        exp_idx = 0; reads = 0; writes = 0; wait_cnt = 0; steps = 0; seen_done = 0;
        exp_wdata = 16'hBABA - sum_to(CK);
        if (fail_at >= 0) begin
            exp_err = 1; exp_reads = fail_at + 1; exp_writes = 0;
        end else if (mode) begin
            exp_err = wfail; exp_reads = CK; exp_writes = 1;
        end else begin
            exp_err = (sum_to(CK + 1) != 16'hBABA); exp_reads = CK + 1; exp_writes = 0;
        end
        @(negedge clk);
        start_i = 1'b1; mode_i = mode;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
        chk(err_o == 1'b0, "R9 err cleared by start", err_o, 0);
        while (!seen_done) begin
            steps++;
            if (steps > 5000) begin
                chk(1'b0, "watchdog op", steps, 5000);
                break;
            end
            start_i = 1'b0;
            if (done_o) begin
                seen_done = 1;
                chk(err_o == exp_err, mode ? "R3/R5 err at done" : "R2/R4 err at done", err_o, exp_err);
                chk(reads == exp_reads, "R1 R3 R4 read count", reads, exp_reads);
                chk(writes == exp_writes, "R3 write count", writes, exp_writes);
                @(negedge clk);
                chk(!done_o && !busy_o, "R7 single done pulse", {done_o, busy_o}, 0);
                chk(err_o == exp_err, "R9 err held", err_o, exp_err);
                break;
            end
            chk(busy_o == 1'b1, "R7 busy during op", busy_o, 1);
            chk(!(rd_req_o && wr_req_o), "R10 exclusive requests", {rd_req_o, wr_req_o}, 0);
            if (steps == poke_at) begin
                start_i = 1'b1; mode_i = ~mode;
            end
            if (ack_i || fail_i) begin
                ack_i = 1'b0; fail_i = 1'b0; wait_cnt = 0;
            end else if (rd_req_o) begin
                chk(int'(addr_o) == exp_idx, "R1 R6 R10 read address", addr_o, exp_idx);
                if (wait_cnt >= lat) begin
                    if (exp_idx == fail_at) fail_i = 1'b1;
                    else begin ack_i = 1'b1; rdata_i = mem[addr_o]; end
                    exp_idx++; reads++;
                end else wait_cnt++;
            end else if (wr_req_o) begin
                chk(int'(addr_o) == CK, "R3 write address", addr_o, CK);
                chk(wdata_o == exp_wdata, "R3 write data", wdata_o, exp_wdata);
                if (wait_cnt >= lat) begin
                    if (wfail) fail_i = 1'b1;
                    else begin ack_i = 1'b1; mem[CK] = wdata_o; end
                    writes++;
                end else wait_cnt++;
            end
            @(negedge clk);
        end
        start_i = 1'b0; ack_i = 1'b0; fail_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({busy_o, done_o, rd_req_o, wr_req_o, err_o} == 5'b0, "R8 reset outputs",
            {busy_o, done_o, rd_req_o, wr_req_o, err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, done_o, rd_req_o, wr_req_o, err_o} == 5'b0, "R8 idle after reset",
            {busy_o, done_o, rd_req_o, wr_req_o, err_o}, 0);

        // good image, check mode
        for (int i = 0; i < CK; i++) mem[i] = 16'(i * 16'h1111 + 3);
        mem[CK] = 16'hBABA - sum_to(CK);
        run_op(1'b0, 0, -1, 1'b0, 0);          // R1 R2 pass

        // corrupted image
        mem[5] = mem[5] ^ 16'h0001;
        run_op(1'b0, 2, -1, 1'b0, 0);          // R2 fail
        repeat (4) @(negedge clk);
        chk(err_o == 1'b1, "R9 err held while idle", err_o, 1);

        // wrapping image, fix then check
        for (int i = 0; i <= CK; i++) mem[i] = 16'hFFF0 - 16'(i);
        run_op(1'b1, 1, -1, 1'b0, 0);          // R3
        run_op(1'b0, 0, -1, 1'b0, 0);          // R2 with wrap, pass

        // read failure mid-walk
        run_op(1'b0, 1, 10, 1'b0, 0);          // R4
        run_op(1'b1, 0, 0, 1'b0, 0);           // R4 at first index

        // write failure
        mem[CK] = 16'h1234;
        run_op(1'b1, 2, -1, 1'b1, 0);          // R5
        chk(mem[CK] == 16'h1234, "R5 slot untouched", mem[CK], 16'h1234);

        // stray start while busy
        run_op(1'b0, 1, -1, 1'b0, 7);          // R6
        run_op(1'b1, 0, -1, 1'b0, 20);         // R6 in fix mode
        run_op(1'b0, 3, -1, 1'b0, 0);          // after fix, image passes

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule